// File: doc/BRIEF.md
# Card Access Strobe Sequencer

This block carries out one access on a removable-card bus once an address decoder has found which window the host hit. It takes the window's option word and a read or write request. It then runs three timed phases: address setup, strobe, and hold. During these phases it drives the chip enables, the selected strobe, and the register-select line. It ends with a one-cycle completion pulse to the host.

The length of each phase comes from its own field in the option word. A bus-monitor counter watches the total length of the access and cuts it off with a timeout flag if it grows too long. Read data is captured in a single holding register. Write data is held at the card data pins for the whole access.

A request to a window that is not marked valid, or a write to a write-protected window, never reaches the card. It completes at once with an error.

Top module: `card_strobe_seq`

## Requirements
- R1: A request is taken only while the block is idle. A request raised during an access or during its completion cycle starts nothing, and the block is idle right after that access completes.
- R2: Phase lengths are counted in clock cycles. Setup lasts max(S,1) cycles, the strobe lasts max(T,1) cycles, and hold lasts max(H,1) cycles, so a field of 0 gives one cycle.
- R3: In the option word, S is bits [15:12], H is bits [19:16] and T is bits [11:7].
- R4: The bus-monitor limit is 60 cycles. When max(S,1)+max(T,1)+max(H,1) is 60 or more, the access ends after exactly 60 active cycles. Its completion pulse then carries tmo_o=1 and err_o=0.
- R5: The space is taken from option bits [4:3]: 11 is I/O, 10 is attribute, and 00 or 01 is common memory. An I/O access pulses ior_n_o or iow_n_o. Every other access pulses oe_n_o (read) or we_n_o (write). At most one strobe is ever low, and only during the strobe phase.
- R6: reg_n_o is low through all three phases of an attribute access and high otherwise.
- R7: Option bit 6 selects a 16-bit window. ce_n_o[0] is low through all three phases of every access. ce_n_o[1] is low with it only when bit 6 is set.
- R8: done_o is high for exactly one cycle, which directly follows the last hold cycle. On a normal access err_o and tmo_o are low with it.
- R9: A read captures card_rdata_i on the last strobe cycle and shows it on rdata_o from the completion cycle on. On an 8-bit window only bits [7:0] are kept and the upper bits read zero.
- R10: On a write, card_wdata_o carries the requested data and card_wdata_oe_o is high in every setup, strobe and hold cycle. card_wdata_oe_o is low at all other times.
- R11: Option bit 0 marks the window valid, and option bit 1 write-protects it. A request to an invalid window, or a write to a protected one, gives done_o with err_o in the very next cycle, with no enable or strobe asserted. Reads of a protected window run normally.
- R12: After reset the block is idle. All strobes, enables and reg_n_o are high, done_o and card_wdata_oe_o are low, and rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (taken while idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| opt_i | input | 32 | Option word of the hit window |
| wdata_i | input | 16 | Host write data |
| card_rdata_i | input | 16 | Data from the card |
| card_wdata_o | output | 16 | Data to the card |
| card_wdata_oe_o | output | 1 | Drive enable for card_wdata_o |
| ce_n_o | output | 2 | Byte-lane chip enables, active low |
| oe_n_o | output | 1 | Memory read strobe, active low |
| we_n_o | output | 1 | Memory write strobe, active low |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| reg_n_o | output | 1 | Attribute space select, active low |
| busy_o | output | 1 | Access or completion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was a rejection |
| tmo_o | output | 1 | Completion was a bus-monitor timeout |
| rdata_o | output | 16 | Captured read data |

## Verification
The hardest edge to reach is the boundary of the bus monitor. The summed phase lengths must land exactly on 59, 60 and 61 cycles. Random field values only rarely come near the limit, so directed accesses with setup and hold at 15 and the strobe at 29, 30 and 31 sit on either side of it.

Capturing read data on the last strobe cycle is only visible if the card data changes every cycle. The bench therefore drives a fresh random word in each strobe cycle and expects the last one.

A request raised in the middle of an access is injected separately, to show that it does not start a second access.

// File: rtl/cstr_pkg.sv
package cstr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_STRB  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DONE  = 3'd4
    } cstr_state_e;

    typedef enum logic [1:0] {
        SP_MEM  = 2'b00,
        SP_ALT  = 2'b01,
        SP_ATTR = 2'b10,
        SP_IO   = 2'b11
    } cstr_space_e;

endpackage

// File: rtl/cstr_bus_monitor.sv
module cstr_bus_monitor #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int BM_W = $clog2(LIMIT + 1);

    logic [BM_W-1:0] bm_d, bm_q;

    always_comb begin
        bm_d = run_i ? bm_q + BM_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bm_q <= '0;
        else        bm_q <= bm_d;
    end

    assign expire_o = run_i && (bm_q == BM_W'(LIMIT - 1));

    // counter never passes the limit inside an access
    p_bm_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (bm_q < BM_W'(LIMIT)));

endmodule

// File: rtl/cstr_strobe_map.sv
module cstr_strobe_map
    import cstr_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             strobe_i,
    input  logic             wr_i,
    input  cstr_space_e      space_i,
    input  logic             wide_i,
    output logic [LANES-1:0] ce_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             ior_n_o,
    output logic             iow_n_o,
    output logic             reg_n_o
);
    logic is_io;
    assign is_io = (space_i == SP_IO);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign ce_n_o[g] = !active_i;
        end else begin : g_high
            assign ce_n_o[g] = !(active_i && wide_i);
        end
    end

    assign oe_n_o  = !(strobe_i && !is_io && !wr_i);
    assign we_n_o  = !(strobe_i && !is_io &&  wr_i);
    assign ior_n_o = !(strobe_i &&  is_io && !wr_i);
    assign iow_n_o = !(strobe_i &&  is_io &&  wr_i);
    assign reg_n_o = !(active_i && (space_i == SP_ATTR));

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~oe_n_o, ~we_n_o, ~ior_n_o, ~iow_n_o}));

    p_strobe_in_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_n_o && we_n_o && ior_n_o && iow_n_o) |-> !ce_n_o[0]);

endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
    import cstr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int LIMIT      = 60,
    parameter int STROBE_LSB = 7,
    parameter int STROBE_W   = 5,
    parameter int SETUP_LSB  = 12,
    parameter int SETUP_W    = 4,
    parameter int HOLD_LSB   = 16,
    parameter int HOLD_W     = 4,
    parameter int VALID_BIT  = 0,
    parameter int WPROT_BIT  = 1,
    parameter int SPACE_LSB  = 3,
    parameter int WIDE_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [31:0]       opt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] card_rdata_i,
    output logic [DATA_W-1:0] card_wdata_o,
    output logic              card_wdata_oe_o,
    output logic [1:0]        ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic              ior_n_o,
    output logic              iow_n_o,
    output logic              reg_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              tmo_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = (STROBE_W > SETUP_W)
                         ? ((STROBE_W > HOLD_W) ? STROBE_W : HOLD_W)
                         : ((SETUP_W  > HOLD_W) ? SETUP_W  : HOLD_W);

    typedef struct packed {
        cstr_state_e         st;
        logic [CNT_W-1:0]    cnt;
        logic                wr;
        cstr_space_e         sp;
        logic                wide;
        logic [STROBE_W-1:0] strb;
        logic [HOLD_W-1:0]   hold;
        logic                err;
        logic                tmo;
        logic [DATA_W-1:0]   rdata;
        logic [DATA_W-1:0]   wdata;
    } regs_t;

    regs_t q, d;
    logic  run, expire, in_strobe;
    logic [LANES-1:0] ce_n_w;

    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    assign run       = (q.st == ST_SETUP) || (q.st == ST_STRB) || (q.st == ST_HOLD);
    assign in_strobe = (q.st == ST_STRB);

    cstr_bus_monitor #(.LIMIT(LIMIT)) u_bm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .expire_o (expire)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                d.err = 1'b0;
                d.tmo = 1'b0;
                if (req_i) begin
                    if (!opt_i[VALID_BIT] || (wr_i && opt_i[WPROT_BIT])) begin
                        d.st  = ST_DONE;
                        d.err = 1'b1;
                    end else begin
                        d.st    = ST_SETUP;
                        d.cnt   = len_m1(CNT_W'(opt_i[SETUP_LSB +: SETUP_W]));
                        d.wr    = wr_i;
                        d.sp    = cstr_space_e'(opt_i[SPACE_LSB +: 2]);
                        d.wide  = opt_i[WIDE_BIT];
                        d.strb  = opt_i[STROBE_LSB +: STROBE_W];
                        d.hold  = opt_i[HOLD_LSB +: HOLD_W];
                        d.wdata = wdata_i;
                    end
                end
            end
            ST_SETUP: begin
                if (expire) begin
                    d.st  = ST_DONE;
                    d.tmo = 1'b1;
                end else if (q.cnt == '0) begin
                    d.st  = ST_STRB;
                    d.cnt = len_m1(CNT_W'(q.strb));
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_STRB: begin
                if (q.cnt == '0 && !q.wr) begin
                    d.rdata = q.wide ? card_rdata_i
                                     : {{(DATA_W-8){1'b0}}, card_rdata_i[7:0]};
                end
                if (expire) begin
                    d.st  = ST_DONE;
                    d.tmo = 1'b1;
                end else if (q.cnt == '0) begin
                    d.st  = ST_HOLD;
                    d.cnt = len_m1(CNT_W'(q.hold));
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (expire) begin
                    d.st  = ST_DONE;
                    d.tmo = 1'b1;
                end else if (q.cnt == '0) begin
                    d.st = ST_DONE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    cstr_strobe_map #(.LANES(LANES)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (run),
        .strobe_i (in_strobe),
        .wr_i     (q.wr),
        .space_i  (q.sp),
        .wide_i   (q.wide),
        .ce_n_o   (ce_n_w),
        .oe_n_o   (oe_n_o),
        .we_n_o   (we_n_o),
        .ior_n_o  (ior_n_o),
        .iow_n_o  (iow_n_o),
        .reg_n_o  (reg_n_o)
    );

    assign ce_n_o          = ce_n_w[1:0];
    assign card_wdata_o    = q.wdata;
    assign card_wdata_oe_o = run && q.wr;
    assign busy_o          = (q.st != ST_IDLE);
    assign done_o          = (q.st == ST_DONE);
    assign err_o           = done_o && q.err;
    assign tmo_o           = done_o && q.tmo;
    assign rdata_o         = q.rdata;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && !opt_i[VALID_BIT]) |=> (done_o && err_o && ce_n_o[0]));

    p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (done_o && tmo_o && !err_o));

    p_wdata_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        card_wdata_oe_o |-> !ce_n_o[0]);

    p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n_o[1] |-> !ce_n_o[0]);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (&ce_n_o && reg_n_o && !card_wdata_oe_o));

endmodule

// File: tb/tb_card_strobe_seq.sv
module tb_card_strobe_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [31:0] opt_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] card_rdata_i = '0;
    logic [15:0] card_wdata_o;
    logic        card_wdata_oe_o;
    logic [1:0]  ce_n_o;
    logic        oe_n_o, we_n_o, ior_n_o, iow_n_o, reg_n_o;
    logic        busy_o, done_o, err_o, tmo_o;
    logic [15:0] rdata_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_strobe_seq dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .opt_i(opt_i),
        .wdata_i(wdata_i), .card_rdata_i(card_rdata_i),
        .card_wdata_o(card_wdata_o), .card_wdata_oe_o(card_wdata_oe_o),
        .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .we_n_o(we_n_o),
        .ior_n_o(ior_n_o), .iow_n_o(iow_n_o), .reg_n_o(reg_n_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tmo_o(tmo_o),
        .rdata_o(rdata_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_opt(input bit valid, input bit wprot,
            input logic [1:0] sp, input bit wide,
            input int s, input int t, input int h);
        logic [31:0] o;
        o = '0;
        o[0]     = valid;
        o[1]     = wprot;
        o[4:3]   = sp;
        o[6]     = wide;
        o[11:7]  = t[4:0];
        o[15:12] = s[3:0];
        o[19:16] = h[3:0];
        return o;
    endfunction

    function automatic int plen(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // low-active strobe mask {oe,we,ior,iow}, bit set = expected low
    function automatic logic [3:0] exp_strb(input logic [1:0] sp, input bit wr);
        if (sp == 2'b11) return wr ? 4'b0001 : 4'b0010;
        return wr ? 4'b0100 : 4'b1000;
    endfunction

    task automatic access(input bit valid, input bit wprot, input logic [1:0] sp,
                          input bit wide, input int s, input int t, input int h,
                          input bit wr, input logic [15:0] wd, input int poke_at);
        int pre = 0, strb = 0, post = 0, act = 0, cyc = 0;
        bit seen = 0, got_done = 0, g_err = 0, g_tmo = 0;
        bit bad_kind = 0, bad_reg = 0, bad_ce = 0, bad_wd = 0;
        logic [15:0] last = '0;
        logic [3:0]  lowm;
        logic [3:0]  em;
        bit reject;
        int tot;
        reject = !valid || (wr && wprot);
        tot = plen(s) + plen(t) + plen(h);
        em  = exp_strb(sp, wr);
        @(negedge clk);
        opt_i = mk_opt(valid, wprot, sp, wide, s, t, h);
        wr_i = wr; wdata_i = wd; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wdata_i = ~wd;
        for (int k = 0; k < 200; k++) begin
            if (k > 0) @(negedge clk);
            if (req_i) req_i = 1'b0;
            if (done_o) begin
                got_done = 1; g_err = err_o; g_tmo = tmo_o;
                break;
            end
            lowm = ~{oe_n_o, we_n_o, ior_n_o, iow_n_o};
            if (!ce_n_o[0]) begin
                act++;
                if (lowm != 4'b0000) begin
                    strb++; seen = 1;
                    if (lowm != em) bad_kind = 1;
                    if (!wr) begin
                        last = 16'($urandom);
                        card_rdata_i = last;
                    end
                end else if (!seen) pre++;
                else post++;
                if (reg_n_o != (sp != 2'b10)) bad_reg = 1;
                if (ce_n_o[1] != !wide) bad_ce = 1;
                if (wr ? !(card_wdata_oe_o && card_wdata_o == wd) : card_wdata_oe_o) bad_wd = 1;
            end else begin
                if (lowm != 4'b0000 || card_wdata_oe_o || !ce_n_o[1] || !reg_n_o) bad_kind = 1;
            end
            cyc++;
            if (cyc == poke_at) begin
                req_i = 1'b1;
                opt_i = mk_opt(1, 0, 2'b00, 1, 1, 1, 1);
            end
        end
        if (reject) begin
            chk(got_done && g_err && !g_tmo && act == 0 && cyc == 0, "R11 reject",
                {g_err, act[15:0]}, {1'b1, 16'd0});
        end else if (tot >= LIMIT) begin
            chk(got_done && g_tmo && !g_err, "R4 timeout flag", {g_tmo, g_err}, 2);
            chk(act == LIMIT, "R4 active cycles at limit", act, LIMIT);
        end else begin
            chk(got_done && !g_err && !g_tmo, "R8 normal completion", {g_err, g_tmo}, 0);
            chk(pre == plen(s), "R2 R3 setup cycles", pre, plen(s));
            chk(strb == plen(t), "R2 R3 strobe cycles", strb, plen(t));
            chk(post == plen(h), "R2 R3 hold cycles", post, plen(h));
            if (!wr)
                chk(rdata_o == (wide ? last : {8'h00, last[7:0]}), "R9 read capture",
                    rdata_o, wide ? last : {8'h00, last[7:0]});
        end
        if (!reject) begin
            chk(!bad_kind, "R5 strobe type", bad_kind, 0);
            chk(!bad_reg, "R6 register select", bad_reg, 0);
            chk(!bad_ce, "R7 byte enables", bad_ce, 0);
            chk(!bad_wd, "R10 write data drive", bad_wd, 0);
        end
        @(negedge clk);
        chk(!busy_o && !done_o, "R8 single pulse then idle", {busy_o, done_o}, 0);
        if (poke_at > 0) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(!busy_o && ce_n_o[0], "R1 request while busy ignored", busy_o, 0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && &ce_n_o && oe_n_o && we_n_o && ior_n_o && iow_n_o
            && reg_n_o && !card_wdata_oe_o, "R12 outputs during reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && rdata_o == 16'h0 && &ce_n_o, "R12 reset state", rdata_o, 0);

        // directed corners
        access(1, 0, 2'b00, 1, 0, 0, 0, 0, 16'h0, 0);      // R2 zero counts
        access(1, 0, 2'b00, 1, 3, 5, 2, 1, 16'hA55A, 0);   // R3 distinct fields
        access(1, 0, 2'b10, 0, 2, 4, 6, 0, 16'h0, 0);      // R6 attribute, R9 8-bit
        access(1, 0, 2'b11, 1, 1, 2, 3, 0, 16'h0, 0);      // R5 io read
        access(1, 0, 2'b11, 0, 4, 1, 1, 1, 16'h1234, 0);   // R5 io write
        access(1, 0, 2'b01, 1, 2, 2, 2, 1, 16'hBEEF, 0);   // R5 alt memory
        access(1, 0, 2'b00, 1, 15, 29, 15, 0, 16'h0, 0);   // R4 59 cycles normal
        access(1, 0, 2'b00, 1, 15, 30, 15, 1, 16'h7777, 0);// R4 60 timeout
        access(1, 0, 2'b11, 1, 15, 31, 15, 0, 16'h0, 0);   // R4 61 timeout
        access(0, 0, 2'b00, 1, 2, 2, 2, 0, 16'h0, 0);      // R11 invalid
        access(1, 1, 2'b00, 1, 2, 2, 2, 1, 16'h5555, 0);   // R11 protected write
        access(1, 1, 2'b10, 1, 2, 3, 2, 0, 16'h0, 0);      // R11 protected read runs
        access(1, 0, 2'b00, 1, 2, 3, 2, 0, 16'h0, 3);      // R1 poke mid access
        access(1, 0, 2'b10, 0, 1, 1, 1, 1, 16'h00C3, 2);   // R1 poke on write

        for (int i = 0; i < 60; i++) begin
            access(($urandom % 8) != 0, $urandom % 4 == 0, 2'($urandom),
                   1'($urandom), int'($urandom % 16), int'($urandom % 32),
                   int'($urandom % 16), 1'($urandom), 16'($urandom), 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule